// File: doc/BRIEF.md
# Selectable Output Word Rate Timer

This block paces a converter's output words. It counts master-clock cycles and raises a one-cycle data-ready strobe each time a conversion period ends. A 4-bit rate code and a rate-family select bit set the period. Family A uses `BASE_A` master clocks at the fastest rate, which is 1280 clocks at 3840 words/s from a 4.9152 MHz clock. Family B uses `BASE_B` clocks at the fastest rate, which is 1536 clocks at 3200 words/s. Family B therefore runs at 5/6 the word rate of family A. Each slower code doubles the period, down to 7.5 or 6.25 words/s.

A start pulse begins a conversion. When the mode bit is low at start, one conversion runs and the busy flag drops with its strobe. When the mode bit is high at start, conversions repeat back to back. The first period of such a run is lengthened by a start-up overhead of `OVH_PERIODS` nominal periods. A continuous run ends at the first strobe for which the mode bit is low. The rate code, family bit and mode bit are captured when a conversion starts.

Top module: `word_rate_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy_o` and `drdy_o` are 0.
- R2: With `fam_sel_i`=0 the period is `BASE_A` << k master-clock cycles. k is 0 for `rate_code_i`=4'b1000, 1 for 4'b1001, 2 for 4'b1010, 3 for 4'b1011, 4 for 4'b1100, 5 for 4'b0000, 6 for 4'b0001, 7 for 4'b0010, 8 for 4'b0011 and 9 for 4'b0100.
- R3: With `fam_sel_i`=1 the same code-to-k map applies with base `BASE_B` in place of `BASE_A`.
- R4: The unused codes 4'b0101, 4'b0110, 4'b0111, 4'b1101, 4'b1110 and 4'b1111 select k=9, the slowest rate.
- R5: Assume `start_i` is sampled high at clock edge E0 while `busy_o` is 0 and `mode_i` is 0. Then `busy_o` is 1 after E0. `drdy_o` is high for exactly the one cycle after edge E0+P, where P is the period. `busy_o` falls at that same edge.
- R6: If `mode_i` is 1 at the starting edge, the first strobe comes (1+`OVH_PERIODS`)×P edges after the start. Every later strobe follows the previous one by P edges, and `busy_o` stays 1 between strobes.
- R7: In a continuous run, if `mode_i` is 0 at the edge that raises a strobe, `busy_o` falls with that strobe and no further strobe follows.
- R8: A start pulse that arrives while a conversion is in progress, other than at its completing edge, is ignored. A change of rate code, family bit or mode during a conversion does not change that conversion's length.
- R9: A start pulse at the edge that completes a single conversion (or ends a continuous run) still produces the strobe. It immediately begins a new conversion, taking its settings from that edge, and `busy_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_code_i | input | 4 | Word-rate code |
| fam_sel_i | input | 1 | Rate family select (1 = 5/6 rate family) |
| mode_i | input | 1 | 0 = single conversion, 1 = continuous |
| start_i | input | 1 | Start pulse |
| drdy_o | output | 1 | One-cycle conversion-complete strobe |
| busy_o | output | 1 | Conversion in progress |

## Verification
A new start and the completion of a conversion can land on the same clock edge. In that case the strobe must still fire while a fresh conversion starts, so `busy_o` never drops. The bench provokes this by raising `start_i` in the cycle before the predicted completion edge, in both the single-conversion case and at the end of a continuous run. It judges the result by checking the strobe, the unbroken busy flag, and the length of the following conversion computed from the new settings. Random runs with a fixed seed cover all sixteen codes, both families and mid-conversion start and setting changes.

// File: rtl/word_rate_timer_pkg.sv
package word_rate_timer_pkg;

    localparam int unsigned MAX_SHIFT = 9;

    // Map a rate code to the power-of-two multiplier of the fastest period.
    function automatic logic [3:0] code_to_shift(input logic [3:0] code);
        logic [3:0] k;
        unique case (code)
            4'b1000: k = 4'd0;
            4'b1001: k = 4'd1;
            4'b1010: k = 4'd2;
            4'b1011: k = 4'd3;
            4'b1100: k = 4'd4;
            4'b0000: k = 4'd5;
            4'b0001: k = 4'd6;
            4'b0010: k = 4'd7;
            4'b0011: k = 4'd8;
            default: k = 4'(MAX_SHIFT);   // 0100 and all unused codes
        endcase
        return k;
    endfunction

endpackage

// File: rtl/word_rate_decode.sv
module word_rate_decode #(
    parameter int unsigned BASE_A = 1280,
    parameter int unsigned BASE_B = 1536,
    parameter int unsigned CNT_W  = 24
) (
    input  logic [3:0]       rate_code_i,
    input  logic             fam_sel_i,
    output logic [CNT_W-1:0] period_o
);
    import word_rate_timer_pkg::*;

    logic [3:0]       shift;
    logic [CNT_W-1:0] base_sel;

    always_comb begin
        shift    = code_to_shift(rate_code_i);
        base_sel = fam_sel_i ? CNT_W'(BASE_B) : CNT_W'(BASE_A);
        period_o = base_sel << shift;
    end

endmodule

// File: rtl/word_rate_seq.sv
module word_rate_seq #(
    parameter int unsigned CNT_W       = 24,
    parameter int unsigned OVH_PERIODS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic             mode_i,
    input  logic             start_i,
    output logic             drdy_o,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] FIRST_MULT = CNT_W'(OVH_PERIODS + 1);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic             cont;
        logic             drdy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.drdy = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cont = mode_i;
                st_d.per  = period_i;
                st_d.cnt  = mode_i ? (period_i * FIRST_MULT) - ONE : period_i - ONE;
            end
        end else if (st_q.cnt == '0) begin
            st_d.drdy = 1'b1;
            if (st_q.cont && mode_i) begin
                st_d.cnt = st_q.per - ONE;
            end else if (start_i) begin
                st_d.cont = mode_i;
                st_d.per  = period_i;
                st_d.cnt  = mode_i ? (period_i * FIRST_MULT) - ONE : period_i - ONE;
            end else begin
                st_d.busy = 1'b0;
                st_d.cont = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drdy_o = st_q.drdy;
    assign busy_o = st_q.busy;

endmodule

// File: rtl/word_rate_timer.sv
module word_rate_timer #(
    parameter int unsigned BASE_A      = 1280,
    parameter int unsigned BASE_B      = 1536,
    parameter int unsigned OVH_PERIODS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rate_code_i,
    input  logic       fam_sel_i,
    input  logic       mode_i,
    input  logic       start_i,
    output logic       drdy_o,
    output logic       busy_o
);
    localparam int unsigned BASE_MAX = (BASE_A > BASE_B) ? BASE_A : BASE_B;
    localparam longint unsigned LONGEST =
        longint'(BASE_MAX) * longint'(OVH_PERIODS + 1) * (64'd1 << word_rate_timer_pkg::MAX_SHIFT);
    localparam int unsigned CNT_W = $clog2(LONGEST) + 1;

    logic [CNT_W-1:0] period;

    word_rate_decode #(
        .BASE_A (BASE_A),
        .BASE_B (BASE_B),
        .CNT_W  (CNT_W)
    ) decode_i (
        .rate_code_i (rate_code_i),
        .fam_sel_i   (fam_sel_i),
        .period_o    (period)
    );

    word_rate_seq #(
        .CNT_W       (CNT_W),
        .OVH_PERIODS (OVH_PERIODS)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period),
        .mode_i   (mode_i),
        .start_i  (start_i),
        .drdy_o   (drdy_o),
        .busy_o   (busy_o)
    );

endmodule

// File: rtl/word_rate_timer_chk.sv
module word_rate_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_i,
    input logic start_i,
    input logic drdy_o,
    input logic busy_o
);
    // R5: the strobe lasts one cycle
    a_r5_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_o |=> !drdy_o);

    // R5: a strobe only ends a conversion that was running
    a_r5_strobe_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_o |-> $past(busy_o));

    // R5, R7: busy drops only together with a strobe
    a_r7_busy_drop_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> drdy_o);

    // R5: a start while idle sets busy
    a_r5_idle_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R8: busy never rises without a start
    a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R6: a continuous run never drops busy while mode stays high at its strobes
    a_r6_cont_holds_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_i && !$past(busy_o)) |=> busy_o);

endmodule

bind word_rate_timer word_rate_timer_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .start_i (start_i),
    .drdy_o  (drdy_o),
    .busy_o  (busy_o)
);

// File: tb/word_rate_timer_tb_top.sv
`timescale 1ns/1ps
module word_rate_timer_tb_top;
    localparam int BA  = 4;
    localparam int BB  = 5;
    localparam int OVH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [3:0] rate_code_i = '0;
    logic       fam_sel_i = 1'b0;
    logic       mode_i = 1'b0;
    logic       start_i = 1'b0;
    logic       drdy_o, busy_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    word_rate_timer #(.BASE_A(BA), .BASE_B(BB), .OVH_PERIODS(OVH)) dut_i (
        .clk(clk), .rst_n(rst_n), .rate_code_i(rate_code_i), .fam_sel_i(fam_sel_i),
        .mode_i(mode_i), .start_i(start_i), .drdy_o(drdy_o), .busy_o(busy_o));

    function automatic int exp_shift(input logic [3:0] c);
        case (c)
            4'b1000: return 0;
            4'b1001: return 1;
            4'b1010: return 2;
            4'b1011: return 3;
            4'b1100: return 4;
            4'b0000: return 5;
            4'b0001: return 6;
            4'b0010: return 7;
            4'b0011: return 8;
            default: return 9;
        endcase
    endfunction

    function automatic int exp_period(input logic [3:0] c, input logic f);
        return (f ? BB : BA) << exp_shift(c);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges after the starting edge until drdy is seen (or limit).
    task automatic wait_strobe(output int n, input int limit, input int start_at);
        n = 0;
        while (!drdy_o && n <= limit) begin
            start_i = (n == start_at);
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
    endtask

    task automatic pulse_start(input logic [3:0] c, input logic f, input logic m);
        rate_code_i = c; fam_sel_i = f; mode_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic single_run(input logic [3:0] c, input logic f, input string req);
        int n, p;
        p = exp_period(c, f);
        pulse_start(c, f, 1'b0);
        check(busy_o == 1'b1, "R5 busy after start", int'(busy_o), 1);
        wait_strobe(n, p + 4, -1);
        check(n == p, req, n, p);
        check(busy_o == 1'b0, "R5 busy clears with strobe", int'(busy_o), 0);
        @(negedge clk);
        check(drdy_o == 1'b0, "R5 strobe one cycle", int'(drdy_o), 0);
    endtask

    initial begin : main
        int n, p, p2;
        logic [3:0] c;
        logic f;
        void'($urandom(32'd1234));
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy_o && !drdy_o, "R1 reset state", int'({busy_o, drdy_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !drdy_o, "R1 after release", int'({busy_o, drdy_o}), 0);

        // R2/R3 directed: every listed code in both families
        for (int i = 0; i < 16; i++) begin
            single_run(4'(i), 1'b0, (i[2:0] > 3'd4 && i != 8 && i != 9 && i != 10 && i != 11 && i != 12)
                       ? "R4 unused code period" : "R2 family A period");
            single_run(4'(i), 1'b1, "R3 family B period");
        end

        // R6/R7 continuous run
        c = 4'b1001; f = 1'b1; p = exp_period(c, f);
        pulse_start(c, f, 1'b1);
        wait_strobe(n, (OVH + 1) * p + 4, -1);
        check(n == (OVH + 1) * p, "R6 first period lengthened", n, (OVH + 1) * p);
        @(negedge clk);
        check(busy_o == 1'b1, "R6 busy held", int'(busy_o), 1);
        rate_code_i = 4'b0100;   // R8: setting change mid-run
        wait_strobe(n, p + 4, -1);
        check(n + 1 == p, "R6 later period", n + 1, p);
        @(negedge clk);
        mode_i = 1'b0;
        wait_strobe(n, p + 4, -1);
        check(n + 1 == p, "R7 last period", n + 1, p);
        check(busy_o == 1'b0, "R7 busy clears at stop", int'(busy_o), 0);
        repeat (3 * p) @(negedge clk);
        check(drdy_o == 1'b0 && busy_o == 1'b0, "R7 no further strobe", int'(drdy_o), 0);

        // R8 start and settings change while busy
        c = 4'b1010; p = exp_period(c, 1'b0);
        pulse_start(c, 1'b0, 1'b0);
        rate_code_i = 4'b0011; fam_sel_i = 1'b1; mode_i = 1'b1;
        wait_strobe(n, p + 4, 2);
        check(n == p, "R8 period unaffected by mid start/settings", n, p);
        check(busy_o == 1'b0, "R8 mid start ignored", int'(busy_o), 0);
        mode_i = 1'b0;
        @(negedge clk);

        // R9 back-to-back start at the completion edge (single)
        c = 4'b1011; p = exp_period(c, 1'b0);
        p2 = exp_period(4'b1000, 1'b1);
        pulse_start(c, 1'b0, 1'b0);
        rate_code_i = 4'b1000; fam_sel_i = 1'b1;
        wait_strobe(n, p + 4, p - 1);
        check(n == p, "R9 strobe on restart edge", n, p);
        check(busy_o == 1'b1, "R9 busy held on restart", int'(busy_o), 1);
        wait_strobe(n, p2 + 4, -1);
        @(negedge clk);
        wait_strobe(n, p2 + 4, -1);
        check(n + 1 == p2, "R9 new conversion length", n + 1, p2);
        check(busy_o == 1'b0, "R9 busy clears after second", int'(busy_o), 0);
        @(negedge clk);

        // R9 restart as a continuous run ends
        c = 4'b1000; p = exp_period(c, 1'b0);
        pulse_start(c, 1'b0, 1'b1);
        wait_strobe(n, (OVH + 1) * p + 4, -1);
        @(negedge clk);
        mode_i = 1'b0; rate_code_i = 4'b1001; fam_sel_i = 1'b0;
        p2 = exp_period(4'b1001, 1'b0);
        wait_strobe(n, p + 4, p - 2);
        check(busy_o == 1'b1, "R9 restart at continuous stop", int'(busy_o), 1);
        @(negedge clk);
        wait_strobe(n, p2 + 4, -1);
        check(n + 1 == p2, "R9 restarted single length", n + 1, p2);
        @(negedge clk);

        // Random single runs (R2, R3, R4)
        for (int i = 0; i < 40; i++) begin
            c = 4'($urandom_range(0, 15));
            f = 1'($urandom_range(0, 1));
            single_run(c, f, (exp_shift(c) == 9) ? "R4 random period" : (f ? "R3 random period" : "R2 random period"));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

endmodule